// File: doc/BRIEF.md
# Parity Bus Transceiver with Error Latch

This block sits between two parallel data buses, side A and side B. Side B carries a parity bit next to its data. When the block forwards data from A to B, it computes odd parity over the data word and drives that bit next to the data. When it forwards data from B to A, it checks the received word and its parity bit together. A mismatch raises an error indication.

Two active-low enables choose what the block does. It can send A to B, send B to A, isolate both buses, or run a diagnostic A-to-B transfer. In the diagnostic transfer the parity bit is deliberately inverted, so a checker further down the bus sees an error.

The error indication goes through a capture stage controlled by a latch enable and an active-low clear:

- **Latch enable high:** the stage is transparent and the output follows the live check.
- **Latch enable low:** the output shows the value captured at the last clock edge on which the latch enable was high.
- **Clear low:** the stage is forced to the no-error state.

Each three-state pad is modelled as separate input, output and enable ports. The error pad is modelled as an open-drain flag plus a drive enable.

Top module: `parity_xcvr`

## Requirements
- R1: With `ab_en_n`=0 and `ba_en_n`=1 (A to B), `b_out` equals `a_in` without inversion. `b_oe` and `par_oe` are 1 and `a_oe` is 0.
- R2: In A-to-B mode, `par_out` makes the total number of ones in {`b_out`,`par_out`} odd.
- R3: With `ba_en_n`=0 and `ab_en_n`=1 (B to A), `a_out` equals `b_in` without inversion. `a_oe` is 1, and `b_oe` and `par_oe` are 0.
- R4: In B-to-A mode, with `le`=1 and `clr_n`=1, the error flag is asserted exactly when {`b_in`,`par_in`} holds an even number of ones. The flag follows the bus in the same cycle.
- R5: With both enables high, `a_oe`, `b_oe` and `par_oe` are all 0.
- R6: With both enables low (diagnostic mode), the block behaves as follows:
  - `b_out` equals `a_in`.
  - `b_oe` and `par_oe` are 1 and `a_oe` is 0.
  - {`b_out`,`par_out`} holds an even number of ones.
- R7: While `le`=0 and `clr_n`=1, the error flag is the value of the live check at the last rising clock edge on which `le` was 1. Changes on the bus do not affect it.
- R8: While `clr_n`=0, the error flag is deasserted whatever `le` and the bus are doing. A flag held afterwards with `le`=0 stays deasserted.
- R9: When B to A is not selected, the live check reports no error. With `le`=1, the flag stays deasserted even if `b_in` and `par_in` carry bad parity.
- R10: The error pad is active low. When an error is flagged, `err_n`=0 and `err_oe`=1. Otherwise `err_n`=1 and `err_oe`=0, so the line is released.
- R11: After reset, with `le`=0, the flag is deasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the error capture stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| ab_en_n | input | 1 | Active-low enable of the B-side drivers (A to B) |
| ba_en_n | input | 1 | Active-low enable of the A-side drivers (B to A) |
| a_in | input | W | Data received from the A pads |
| a_out | output | W | Data to drive onto the A pads |
| a_oe | output | 1 | Drive enable for the A pads |
| b_in | input | W | Data received from the B pads |
| b_out | output | W | Data to drive onto the B pads |
| b_oe | output | 1 | Drive enable for the B data pads |
| par_in | input | 1 | Parity bit received from the B side |
| par_out | output | 1 | Parity bit to drive onto the B side |
| par_oe | output | 1 | Drive enable for the parity pad |
| le | input | 1 | Latch enable: 1 transparent, 0 hold |
| clr_n | input | 1 | Active-low clear of the error stage, overrides `le` |
| err_n | output | 1 | Active-low error flag |
| err_oe | output | 1 | Drive enable of the open-drain error pad |

## Verification
The hardest case to reach is a held error that survives after the bus has been corrected. To get there, the stimulus first shows a bad word in B-to-A mode with the latch transparent across a clock edge. It then drops `le`, puts a good word on the bus and changes direction, and checks that the flag stays set. A second sequence clears the held error while `le` is low and then releases the clear. This shows that the cleared state is the one kept, and not the earlier error.

// File: rtl/parity_xcvr.sv
module parity_xcvr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ab_en_n,
  input  logic         ba_en_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  input  logic         par_in,
  output logic         par_out,
  output logic         par_oe,
  input  logic         le,
  input  logic         clr_n,
  output logic         err_n,
  output logic         err_oe
);

  logic to_b, to_a, diag, live_err, held_err, flag;

  assign to_b = !ab_en_n;
  assign to_a = !ba_en_n && ab_en_n;
  assign diag = !ab_en_n && !ba_en_n;

  assign b_out   = a_in;
  assign b_oe    = to_b;
  assign par_out = diag ? ^a_in : ~^a_in;
  assign par_oe  = to_b;

  assign a_out = b_in;
  assign a_oe  = to_a;

  assign live_err = to_a && !(^{b_in, par_in});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      held_err <= 1'b0;
    else if (!clr_n) held_err <= 1'b0;
    else if (le)     held_err <= live_err;
  end

  assign flag   = clr_n && (le ? live_err : held_err);
  assign err_n  = !flag;
  assign err_oe = flag;

  assert_isolate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_en_n && ba_en_n) |-> (!a_oe && !b_oe && !par_oe));

  assert_odd_parity_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_en_n && ba_en_n) |-> (^{b_out, par_out}));

  assert_diag_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_en_n && !ba_en_n) |-> !(^{b_out, par_out}));

  assert_one_dir_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_oe && b_oe));

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> !err_oe);

  assert_clear_sticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_n && $past(clr_n)) |=> (le || !clr_n || !err_oe));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && $past(!le) && clr_n && $past(clr_n)) |-> $stable(err_oe));

  assert_no_check_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ba_en_n && le) |-> !err_oe);

  assert_pad_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_oe |-> !err_n);

endmodule

// File: tb/parity_xcvr_test.sv
module parity_xcvr_test;
  localparam int W = 8;
  logic clk = 0, rst_n = 0;
  logic ab_en_n = 1, ba_en_n = 1, par_in = 0, le = 0, clr_n = 1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe, par_out, par_oe, err_n, err_oe;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  parity_xcvr #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .ab_en_n(ab_en_n), .ba_en_n(ba_en_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .par_in(par_in), .par_out(par_out), .par_oe(par_oe),
    .le(le), .clr_n(clr_n), .err_n(err_n), .err_oe(err_oe));

  function automatic int ones(input logic [W-1:0] v, input logic p);
    int n = int'(p);
    for (int i = 0; i < W; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_flag(input bit exp, input string req);
    check(err_oe == exp && err_n == !exp, req, {err_oe, err_n}, {exp, !exp});
  endtask

  task automatic apply(input logic ea, input logic eb, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic p);
    @(negedge clk);
    ab_en_n = ea; ba_en_n = eb; a_in = a; b_in = b; par_in = p;
    #2;
  endtask

  task automatic t_reset;
    le = 0;
    apply(1, 1, 8'h00, 8'h00, 0);
    check_flag(0, "R11");
    check(!a_oe && !b_oe && !par_oe, "R5", {a_oe, b_oe, par_oe}, 0);
  endtask

  task automatic t_a_to_b;
    logic [W-1:0] pats [4] = '{8'h00, 8'hFF, 8'hA5, 8'h01};
    foreach (pats[i]) begin
      apply(0, 1, pats[i], 8'h3C, 0);
      check(b_out == pats[i] && b_oe && par_oe && !a_oe, "R1", b_out, pats[i]);
      check(ones(b_out, par_out) % 2 == 1, "R2", par_out, !(ones(pats[i], 0) % 2));
    end
  endtask

  task automatic t_b_to_a;
    le = 1;
    apply(1, 0, 8'h55, 8'h96, 1);
    check(a_out == 8'h96 && a_oe && !b_oe && !par_oe, "R3", a_out, 8'h96);
    check_flag(0, "R4 good odd");
    apply(1, 0, 8'h55, 8'h96, 0);
    check_flag(1, "R4 bad even");
    apply(1, 0, 8'h55, 8'h07, 0);
    check_flag(0, "R4 odd word");
    apply(1, 0, 8'h55, 8'h00, 0);
    check_flag(1, "R10 zero word");
  endtask

  task automatic t_isolate;
    le = 1;
    apply(1, 1, 8'h12, 8'h00, 0);
    check(!a_oe && !b_oe && !par_oe, "R5", {a_oe, b_oe, par_oe}, 0);
    check_flag(0, "R9 isolated");
    apply(0, 1, 8'h12, 8'h00, 0);
    check_flag(0, "R9 a_to_b");
  endtask

  task automatic t_diag;
    apply(0, 0, 8'h5A, 8'h00, 0);
    check(b_out == 8'h5A && b_oe && par_oe && !a_oe, "R6", b_out, 8'h5A);
    check(ones(b_out, par_out) % 2 == 0, "R6 parity", par_out, ones(8'h5A, 0) % 2);
    apply(0, 0, 8'h01, 8'h00, 0);
    check(par_out == 1'b1, "R6 parity", par_out, 1);
  endtask

  task automatic t_hold;
    le = 1;
    apply(1, 0, 8'h00, 8'h03, 0);
    @(negedge clk);
    le = 0;
    #1;
    check_flag(1, "R7 held");
    apply(1, 0, 8'h00, 8'h03, 1);
    check_flag(1, "R7 bus fixed");
    apply(0, 1, 8'h44, 8'h00, 0);
    check_flag(1, "R7 direction");
    le = 1;
    apply(1, 0, 8'h00, 8'h01, 0);
    @(negedge clk);
    le = 0;
    apply(1, 0, 8'h00, 8'h00, 0);
    check_flag(0, "R7 held clean");
  endtask

  task automatic t_clear;
    le = 1;
    apply(1, 0, 8'h00, 8'hF0, 0);
    check_flag(1, "R4 before clear");
    clr_n = 0;
    #1;
    check_flag(0, "R8 over le");
    @(negedge clk);
    le = 0;
    @(negedge clk);
    clr_n = 1;
    #1;
    check_flag(0, "R8 held clear");
    @(negedge clk);
    #1;
    check_flag(0, "R8 stays");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_a_to_b();
    t_b_to_a();
    t_isolate();
    t_diag();
    t_hold();
    t_clear();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule